// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address order for a single burst on a synchronous DRAM. When a burst opens it captures the start column and the burst settings. After that it presents one column address per enabled clock, until the burst finishes or a stop request cuts it short. A controller reads the address and two flags straight off the ports. `lastBeat` marks the final column of a finite burst. `done` pulses once, in the cycle after the burst ends.

Two orderings are supported. Sequential order counts up and wraps inside the aligned block. Interleaved order combines the start column with the beat index by XOR. There is also a full-page mode that walks all 256 columns round and round until it is stopped. A single-write mode shortens every write burst to one beat and leaves reads unchanged.

Top module: `burst_col_gen`

## Requirements
- R1: The length code on `lenCode` sets the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page (256 columns, no natural end).
- R2: With `wrapInterleave`=0, beat i presents the start column plus i, wrapped inside the aligned block of the burst length. Column bits above that block keep their start values (for example, length 4 from 0x12 gives 0x12, 0x13, 0x10, 0x11).
- R3: With `wrapInterleave`=1, beat i presents the start column with its block bits XORed with i (for example, length 8 from 0x35 gives 0x35, 0x34, 0x37, 0x36, 0x31, 0x30, 0x33, 0x32).
- R4: When `singleWrite`=1 and `isWrite`=1 at the start of a burst, the burst is one beat long whatever the length code. Read bursts keep the programmed length.
- R5: `stopReq` high at a clock edge during a burst (with `start` low) ends the burst. `colValid` is low and `done` is high in the next cycle. `stopReq` while idle has no effect.
- R6: A full-page burst never ends on its own. `lastBeat` stays low throughout, and the address wraps from 0xFF to 0x00.
- R7: `start` high at a clock edge, even during a burst, makes the next cycle present `startCol` as beat 0 of a new burst. No `done` pulse is produced for the abandoned burst.
- R8: Reserved length codes (3'b100, 3'b101, 3'b110) give a one-beat burst. Full page combined with `wrapInterleave`=1 runs sequentially. Both cases set `lenError`, which stays high until reset.
- R9: `lastBeat` is high exactly while the final column of a finite burst is presented. An edge with `advance` high at that point ends the burst, and `done` is high for that next single cycle only.
- R10: While a burst is active and `advance`, `start` and `stopReq` are low, the presented column and beat position do not change.
- R11: After reset, `colValid`, `lastBeat`, `done` and `lenError` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Open a new burst from `startCol` |
| startCol | input | 8 | Start column of the burst |
| lenCode | input | 3 | Burst length code |
| wrapInterleave | input | 1 | 0 = sequential order, 1 = interleaved order |
| isWrite | input | 1 | The burst being opened is a write |
| singleWrite | input | 1 | Force write bursts to one beat |
| advance | input | 1 | Step to the next beat at this edge |
| stopReq | input | 1 | Stop or interrupt the current burst |
| colAddr | output | 8 | Column address of the current beat |
| colValid | output | 1 | A burst is active and `colAddr` is valid |
| lastBeat | output | 1 | Current beat is the final one of a finite burst |
| done | output | 1 | One-cycle pulse after the burst ends |
| lenError | output | 1 | Sticky flag for an invalid length or order setting |

## Verification
A wrong beat counter or a corrupted block mask appears on `colAddr` in the very next enabled cycle. It shows up either as a wrong low-order column or as a change in the fixed upper bits. A length decoded wrongly moves `lastBeat` and the `done` pulse one or more cycles early or late, so every burst is followed through its last beat and the cycle after. A lost active or full-page flag shows as `colValid` dropping early, or as a spurious `lastBeat` during the full-page run that lasts several hundred beats.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic [2:0] {
    LEN_ONE   = 3'd0,
    LEN_TWO   = 3'd1,
    LEN_FOUR  = 3'd2,
    LEN_EIGHT = 3'd3,
    LEN_PAGE  = 3'd7
  } burst_len_e;

  typedef struct packed {
    logic       load;
    logic       step;
    burst_len_e len;
    logic       ilv;
  } col_strobe_t;

endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  lenCode,
  input  logic        wrapInterleave,
  input  logic        isWrite,
  input  logic        singleWrite,
  input  logic        advance,
  input  logic        stopReq,
  input  logic        atLast,
  output col_strobe_t strb,
  output logic        colValid,
  output logic        lastBeat,
  output logic        done,
  output logic        lenError
);

  logic       active;
  logic       fullRun;
  logic       doneR;
  logic       errR;
  burst_len_e lenDec;
  burst_len_e lenEff;
  logic       codeBad;
  logic       ilvBad;
  logic       endNow;

  always_comb begin
    codeBad = 1'b0;
    case (lenCode)
      3'b000:  lenDec = LEN_ONE;
      3'b001:  lenDec = LEN_TWO;
      3'b010:  lenDec = LEN_FOUR;
      3'b011:  lenDec = LEN_EIGHT;
      3'b111:  lenDec = LEN_PAGE;
      default: begin
        lenDec  = LEN_ONE;
        codeBad = 1'b1;
      end
    endcase
    lenEff = (isWrite && singleWrite) ? LEN_ONE : lenDec;
    ilvBad = wrapInterleave && (lenEff == LEN_PAGE);
  end

  assign endNow = active && !start &&
                  (stopReq || (advance && atLast && !fullRun));

  always_comb begin
    strb.load = start;
    strb.step = active && !start && advance && !endNow;
    strb.len  = lenEff;
    strb.ilv  = wrapInterleave && (lenEff != LEN_PAGE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      fullRun <= 1'b0;
      doneR   <= 1'b0;
      errR    <= 1'b0;
    end else begin
      doneR <= endNow;
      if (start) begin
        active  <= 1'b1;
        fullRun <= (lenEff == LEN_PAGE);
        errR    <= errR | codeBad | ilvBad;
      end else if (endNow) begin
        active <= 1'b0;
      end
    end
  end

  assign colValid = active;
  assign lastBeat = active && !fullRun && atLast;
  assign done     = doneR;
  assign lenError = errR;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_stop_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && stopReq && !start) |=> (!colValid && done));

  assert_page_no_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && fullRun && !stopReq) |=> colValid);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    lenError |=> lenError);

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  col_strobe_t      strb,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr,
  output logic             atLast
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] beat;
  logic             ilvR;
  logic [COL_W-1:0] loadMask;
  logic [COL_W-1:0] lowSeq;
  logic [COL_W-1:0] lowIlv;

  always_comb begin
    case (strb.len)
      LEN_ONE:   loadMask = '0;
      LEN_TWO:   loadMask = COL_W'(1);
      LEN_FOUR:  loadMask = COL_W'(3);
      LEN_EIGHT: loadMask = COL_W'(7);
      default:   loadMask = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol <= '0;
      mask    <= '0;
      beat    <= '0;
      ilvR    <= 1'b0;
    end else if (strb.load) begin
      baseCol <= startCol;
      mask    <= loadMask;
      beat    <= '0;
      ilvR    <= strb.ilv;
    end else if (strb.step) begin
      beat <= beat + 1'b1;
    end
  end

  assign lowSeq  = baseCol + beat;
  assign lowIlv  = baseCol ^ beat;
  assign colAddr = (baseCol & ~mask) | ((ilvR ? lowIlv : lowSeq) & mask);
  assign atLast  = (beat == mask);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> $stable(colAddr));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (colAddr == $past(startCol)));

  assert_upper_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (((colAddr ^ $past(colAddr)) & ~mask) == '0));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             wrapInterleave,
  input  logic             isWrite,
  input  logic             singleWrite,
  input  logic             advance,
  input  logic             stopReq,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             lastBeat,
  output logic             done,
  output logic             lenError
);

  col_strobe_t strb;
  logic        atLast;

  burst_col_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .start          (start),
    .lenCode        (lenCode),
    .wrapInterleave (wrapInterleave),
    .isWrite        (isWrite),
    .singleWrite    (singleWrite),
    .advance        (advance),
    .stopReq        (stopReq),
    .atLast         (atLast),
    .strb           (strb),
    .colValid       (colValid),
    .lastBeat       (lastBeat),
    .done           (done),
    .lenError       (lenError)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .startCol (startCol),
    .colAddr  (colAddr),
    .atLast   (atLast)
  );

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       wrapInterleave = 1'b0;
  logic       isWrite = 1'b0;
  logic       singleWrite = 1'b0;
  logic       advance = 1'b0;
  logic       stopReq = 1'b0;
  logic [7:0] colAddr;
  logic       colValid, lastBeat, done, lenError;

  int checks = 0;
  int fails = 0;

  // entry: col, code, ilv, wr, sw, beats, expected addresses (first in top byte)
  localparam logic [81:0] VECS [0:NVEC-1] = '{
    {8'h12, 3'b010, 1'b0, 1'b0, 1'b0, 4'd4, 64'h1213101100000000},
    {8'h35, 3'b011, 1'b1, 1'b0, 1'b0, 4'd8, 64'h3534373631303332},
    {8'h07, 3'b011, 1'b0, 1'b0, 1'b0, 4'd8, 64'h0700010203040506},
    {8'hA1, 3'b001, 1'b0, 1'b0, 1'b0, 4'd2, 64'hA1A0000000000000},
    {8'hA1, 3'b001, 1'b1, 1'b0, 1'b0, 4'd2, 64'hA1A0000000000000},
    {8'h5E, 3'b000, 1'b0, 1'b0, 1'b0, 4'd1, 64'h5E00000000000000},
    {8'h4B, 3'b010, 1'b1, 1'b0, 1'b0, 4'd4, 64'h4B4A494800000000},
    {8'h22, 3'b011, 1'b0, 1'b1, 1'b1, 4'd1, 64'h2200000000000000},
    {8'h22, 3'b010, 1'b0, 1'b0, 1'b1, 4'd4, 64'h2223202100000000},
    {8'h23, 3'b001, 1'b0, 1'b1, 1'b0, 4'd2, 64'h2322000000000000},
    {8'h90, 3'b101, 1'b0, 1'b0, 1'b0, 4'd1, 64'h9000000000000000}
  };

  burst_col_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
    .lenCode(lenCode), .wrapInterleave(wrapInterleave), .isWrite(isWrite),
    .singleWrite(singleWrite), .advance(advance), .stopReq(stopReq),
    .colAddr(colAddr), .colValid(colValid), .lastBeat(lastBeat),
    .done(done), .lenError(lenError)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic openBurst(input logic [7:0] col, input logic [2:0] code,
                           input logic ilv, input logic wr, input logic sw);
    @(negedge clk);
    start = 1'b1; startCol = col; lenCode = code;
    wrapInterleave = ilv; isWrite = wr; singleWrite = sw; advance = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runVec(input string tag, input logic [81:0] v);
    int n;
    n = int'(v[67:64]);
    openBurst(v[81:74], v[73:71], v[70], v[69], v[68]);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      check({tag, " valid"}, 32'(colValid), 32'd1);
      check({tag, " addr"}, 32'(colAddr), 32'(v[63 - 8*i -: 8]));
      check({tag, " last"}, 32'(lastBeat), 32'(i == n - 1));
    end
    @(negedge clk);
    check({tag, " done"}, 32'(done), 32'd1);
    check({tag, " idle"}, 32'(colValid), 32'd0);
    @(negedge clk);
    check({tag, " done pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 colValid", 32'(colValid), 32'd0);
    check("R11 lastBeat", 32'(lastBeat), 32'd0);
    check("R11 done", 32'(done), 32'd0);
    check("R11 lenError", 32'(lenError), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R9
    for (int k = 0; k < NVEC; k++) begin
      if (k == NVEC - 1) check("R8 no error before reserved", 32'(lenError), 32'd0);
      runVec($sformatf("R1/R2/R3/R4/R9 vec%0d", k), VECS[k]);
    end
    check("R8 reserved code sets error", 32'(lenError), 32'd1);

    // R10 hold while advance low
    openBurst(8'h40, 3'b010, 1'b0, 1'b0, 1'b0);
    advance = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R10 hold addr", 32'(colAddr), 32'h40);
      check("R10 hold valid", 32'(colValid), 32'd1);
    end
    advance = 1'b1;
    @(negedge clk);
    check("R10 resume", 32'(colAddr), 32'h41);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;

    // R5 stop mid-burst, then stop while idle
    openBurst(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R5 before stop", 32'(colAddr), 32'h12);
    stopReq = 1'b1;
    @(negedge clk);
    check("R5 stopped valid", 32'(colValid), 32'd0);
    check("R5 stopped done", 32'(done), 32'd1);
    @(negedge clk);
    check("R5 idle stop valid", 32'(colValid), 32'd0);
    check("R5 idle stop done", 32'(done), 32'd0);
    stopReq = 1'b0;

    // R6 full page run with wrap past 0xFF
    openBurst(8'hFD, 3'b111, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 301; i++) begin
      if (i > 0) @(negedge clk);
      if (i < 5 || i == 300) begin
        check("R6 page addr", 32'(colAddr), 32'((8'hFD + i) & 8'hFF));
        check("R6 page valid", 32'(colValid), 32'd1);
      end
      if (lastBeat !== 1'b0) check("R6 page last", 32'(lastBeat), 32'd0);
    end
    check("R6 page last low", 32'(lastBeat), 32'd0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check("R6 page stop done", 32'(done), 32'd1);

    // R7 restart mid-burst
    openBurst(8'h12, 3'b010, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 pre", 32'(colAddr), 32'h13);
    start = 1'b1; startCol = 8'h80; lenCode = 3'b001; wrapInterleave = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 restart addr", 32'(colAddr), 32'h80);
    check("R7 no done", 32'(done), 32'd0);
    @(negedge clk);
    check("R7 second", 32'(colAddr), 32'h81);
    check("R7 last", 32'(lastBeat), 32'd1);
    @(negedge clk);
    check("R7 done", 32'(done), 32'd1);

    // R8 full page with interleave: sequential plus error
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R11 error cleared", 32'(lenError), 32'd0);
    openBurst(8'h03, 3'b111, 1'b1, 1'b0, 1'b0);
    check("R8 page ilv a0", 32'(colAddr), 32'h03);
    @(negedge clk);
    check("R8 page ilv a1", 32'(colAddr), 32'h04);
    @(negedge clk);
    check("R8 page ilv a2", 32'(colAddr), 32'h05);
    check("R8 page ilv error", 32'(lenError), 32'd1);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule